// File: doc/BRIEF.md
# Sorting-Network Balanced-Weight Code Checker

This block classifies an N-bit word by how many of its bits are set and compares that count with a fixed weight M. It is meant for words drawn from a constant-weight code, where every legal word has exactly M ones. The balanced case, where M is half of N, is the default. It also serves one-hot words (M = 1) and the degenerate all-ones case (M = N).

The block does not count with an adder. It routes the word through a binary sorting network made of two-input compare cells. Each cell passes the OR of its inputs toward the ones end and the AND toward the zeros end, so the network output is a run of k ones followed by N-k zeros. Two taps on that sorted run then give the result. Tap M is the completion flag, which is set once at least M ones have arrived. Tap M+1 is the error flag, which is set when more than M ones are present.

For N = 4 a fixed five-cell network is built. Every other N uses a generated odd-even transposition network of N stages. The block is purely combinational.

Top module: `mofn_checker`

## Requirements
- R1: A word with exactly M ones drives `done_o` high and `err_o` low.
- R2: `done_o` is 1 exactly when the word holds M or more ones.
- R3: With M below N, `err_o` is 1 exactly when the word holds more than M ones.
- R4: A word with fewer than M ones drives both `done_o` and `err_o` low.
- R5: `err_o` is never 1 while `done_o` is 0.
- R6: The outputs depend only on the number of ones, not on which bit positions hold them (for N=6, M=3: 000111, 111000 and 101010 all give done 1, err 0).
- R7: The all-zeros word gives done 0 and err 0. With M below N, the all-ones word gives done 1 and err 1.
- R8: With M equal to N, `err_o` stays 0 for every word, and `done_o` is 1 only for the all-ones word.
- R9: With N = 4 (the fixed five-cell network), all 16 words are classified as R2 and R3 state.
- R10: With M = 1 the block acts as a one-hot checker: done is set by any nonzero word, and err is set by two or more ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| code_i | input | N | Word under check |
| done_o | output | 1 | At least M ones present (completion) |
| err_o | output | 1 | More than M ones present (error) |

## Verification
A wrong compare cell or a misrouted wire in the network leaves some input counts unsorted. The tap then reads a one or a zero from the wrong position. This shows up at the ports as a wrong done or err flag for the words whose ones reach that cell. Because the block has no state, such a fault shows in the same evaluation as the offending word. An exhaustive sweep for each configuration up to eight bits therefore exposes any such fault, and seeded random words on a twelve-bit instance cover the wider transposition network.

// File: rtl/mofn_pkg.sv
package mofn_pkg;

    typedef enum logic {
        NET_FIXED4    = 1'b0,
        NET_TRANSPOSE = 1'b1
    } net_kind_e;

    function automatic net_kind_e pick_net(input int n);
        if (n == 4) return NET_FIXED4;
        return NET_TRANSPOSE;
    endfunction

endpackage

// File: rtl/mofn_cmp.sv
module mofn_cmp (
    input  logic a_i,
    input  logic b_i,
    output logic hi_o,
    output logic lo_o
);
    // binary compare cell: larger value is the OR, smaller is the AND
    assign hi_o = a_i | b_i;
    assign lo_o = a_i & b_i;
endmodule

// File: rtl/mofn_sort_net.sv
module mofn_sort_net #(
    parameter int N = 6
) (
    input  logic [N-1:0] in_i,
    output logic [N-1:0] out_o   // out_o[0] is the ones end
);
    import mofn_pkg::*;

    localparam net_kind_e KIND = pick_net(N);

    generate
        if (KIND == NET_FIXED4) begin : g_fixed4
            logic [3:0] st1;
            logic [3:0] st2;
            mofn_cmp i_c0 (.a_i(in_i[0]), .b_i(in_i[1]), .hi_o(st1[0]), .lo_o(st1[1]));
            mofn_cmp i_c1 (.a_i(in_i[2]), .b_i(in_i[3]), .hi_o(st1[2]), .lo_o(st1[3]));
            mofn_cmp i_c2 (.a_i(st1[0]),  .b_i(st1[2]),  .hi_o(st2[0]), .lo_o(st2[2]));
            mofn_cmp i_c3 (.a_i(st1[1]),  .b_i(st1[3]),  .hi_o(st2[1]), .lo_o(st2[3]));
            mofn_cmp i_c4 (.a_i(st2[1]),  .b_i(st2[2]),  .hi_o(out_o[1]), .lo_o(out_o[2]));
            assign out_o[0] = st2[0];
            assign out_o[3] = st2[3];
        end else begin : g_transpose
            logic [N-1:0] lvl [N+1];
            assign lvl[0] = in_i;
            for (genvar s = 0; s < N; s++) begin : g_stage
                localparam int P = s % 2;
                for (genvar j = 0; j < N; j++) begin : g_lane
                    if ((j >= P) && (((j - P) % 2) == 0) && (j + 1 < N)) begin : g_cell
                        mofn_cmp i_cmp (
                            .a_i (lvl[s][j]),
                            .b_i (lvl[s][j+1]),
                            .hi_o(lvl[s+1][j]),
                            .lo_o(lvl[s+1][j+1])
                        );
                    end else if ((j > P) && (((j - P) % 2) == 1)) begin : g_lower
                        // driven by the cell of lane j-1
                    end else begin : g_pass
                        assign lvl[s+1][j] = lvl[s][j];
                    end
                end
            end
            assign out_o = lvl[N];
        end
    endgenerate

endmodule

// File: rtl/mofn_checker.sv
module mofn_checker #(
    parameter int N = 6,
    parameter int M = N / 2
) (
    input  logic [N-1:0] code_i,
    output logic         done_o,
    output logic         err_o
);
    logic [N-1:0] sorted_d;

    mofn_sort_net #(.N(N)) i_sort (
        .in_i (code_i),
        .out_o(sorted_d)
    );

    // tap M (1-based) = index M-1; tap M+1 = index M
    assign done_o = sorted_d[M-1];

    generate
        if (M < N) begin : g_err_tap
            assign err_o = sorted_d[M];
        end else begin : g_err_none
            assign err_o = 1'b0;
        end
    endgenerate

    logic unused_taps;
    assign unused_taps = ^sorted_d;

endmodule

// File: rtl/mofn_checker_sva.sv
module mofn_checker_sva #(
    parameter int N = 6,
    parameter int M = N / 2
) (
    input logic [N-1:0] code_i,
    input logic         done_o,
    input logic         err_o
);
    int cnt;
    always_comb begin
        cnt = $countones(code_i);
        p_exact_weight_r1: assert (!(cnt == M) || (done_o && !err_o))
            else $error("exact weight misclassified");
        p_done_threshold_r2: assert (done_o == (cnt >= M))
            else $error("completion flag wrong");
        p_err_threshold_r3: assert (err_o == (cnt > M))
            else $error("error flag wrong");
        p_below_weight_r4: assert (!(cnt < M) || (!done_o && !err_o))
            else $error("underweight word flagged");
        p_err_needs_done_r5: assert (!err_o || done_o)
            else $error("error without completion");
    end
endmodule

bind mofn_checker mofn_checker_sva #(.N(N), .M(M)) i_mofn_checker_sva (
    .code_i(code_i),
    .done_o(done_o),
    .err_o (err_o)
);

// File: tb/test_mofn_checker.sv
module test_mofn_checker;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [3:0]  w4;
    logic [4:0]  w5;
    logic [5:0]  w6;
    logic [7:0]  w8;
    logic [11:0] w12;
    logic d4, e4, d4f, e4f, d5, e5, d6, e6, d8, e8, d12, e12;

    mofn_checker #(.N(4), .M(2))  i_mofn_checker_n4   (.code_i(w4),  .done_o(d4),  .err_o(e4));
    mofn_checker #(.N(4), .M(4))  i_mofn_checker_full (.code_i(w4),  .done_o(d4f), .err_o(e4f));
    mofn_checker #(.N(5), .M(1))  i_mofn_checker_oh   (.code_i(w5),  .done_o(d5),  .err_o(e5));
    mofn_checker                  i_mofn_checker      (.code_i(w6),  .done_o(d6),  .err_o(e6));
    mofn_checker #(.N(8), .M(4))  i_mofn_checker_n8   (.code_i(w8),  .done_o(d8),  .err_o(e8));
    mofn_checker #(.N(12), .M(6)) i_mofn_checker_n12  (.code_i(w12), .done_o(d12), .err_o(e12));

    int n_checks = 0;
    int n_fail   = 0;
    bit done_run = 1'b0;

    function automatic int ones(input logic [11:0] v, input int n);
        int c = 0;
        for (int i = 0; i < n; i++) c += int'(v[i]);
        return c;
    endfunction

    task automatic chk(input string tag, input logic got, input logic exp, input logic [11:0] v);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s word=%h actual=%b expected=%b", tag, v, got, exp);
        end
    endtask

    task automatic check_cfg(input int n, input int m, input logic [11:0] v,
                             input logic d, input logic e, input string extra);
        int k = ones(v, n);
        logic exp_d = (k >= m);
        logic exp_e = (k > m);
        if (k == m)     begin chk("R1", d, 1'b1, v); chk("R1", e, 1'b0, v); end
        else if (k < m) begin chk("R4", d, 1'b0, v); chk("R4", e, 1'b0, v); end
        chk("R2", d, exp_d, v);
        if (m < n) chk("R3", e, exp_e, v);
        else       chk("R8", e, 1'b0, v);
        chk("R5", !e || d, 1'b1, v);
        if (extra != "") begin
            chk(extra, d, exp_d, v);
            chk(extra, e, exp_e, v);
        end
    endtask

    task automatic apply(input logic [11:0] v);
        @(posedge clk);
        w4 = v[3:0]; w5 = v[4:0]; w6 = v[5:0]; w8 = v[7:0]; w12 = v;
        @(negedge clk);
    endtask

    task automatic check_all(input logic [11:0] v);
        check_cfg(4, 2, v, d4, e4, "R9");
        check_cfg(4, 4, v, d4f, e4f, "R8");
        check_cfg(5, 1, v, d5, e5, "R10");
        check_cfg(6, 3, v, d6, e6, "");
        check_cfg(8, 4, v, d8, e8, "");
        check_cfg(12, 6, v, d12, e12, "");
    endtask

    task automatic finish_run;
        if (!done_run) begin
            done_run = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [11:0] rv;
        logic        rd0, re0;
        void'($urandom(32'd1234));
        w4 = '0; w5 = '0; w6 = '0; w8 = '0; w12 = '0;

        // R7: all-zeros and all-ones words
        apply(12'h000);
        chk("R7", d6, 1'b0, 12'h000); chk("R7", e6, 1'b0, 12'h000);
        chk("R7", d12, 1'b0, 12'h000); chk("R7", e12, 1'b0, 12'h000);
        apply(12'hFFF);
        chk("R7", d6, 1'b1, 12'hFFF); chk("R7", e6, 1'b1, 12'hFFF);
        chk("R7", d12, 1'b1, 12'hFFF); chk("R7", e12, 1'b1, 12'hFFF);
        chk("R8", d4f, 1'b1, 12'hFFF); chk("R8", e4f, 1'b0, 12'hFFF);

        // R6: same weight at different positions gives same result
        apply(12'b000111);
        rd0 = d6; re0 = e6;
        chk("R6", rd0, 1'b1, 12'b000111); chk("R6", re0, 1'b0, 12'b000111);
        apply(12'b111000);
        chk("R6", d6, rd0, 12'b111000); chk("R6", e6, re0, 12'b111000);
        apply(12'b101010);
        chk("R6", d6, rd0, 12'b101010); chk("R6", e6, re0, 12'b101010);

        // exhaustive sweep for every width up to 8
        for (int v = 0; v < 256; v++) begin
            apply(12'(v));
            check_all(12'(v));
        end

        // seeded random words, mainly exercising the 12-bit network
        for (int r = 0; r < 400; r++) begin
            rv = 12'($urandom);
            apply(rv);
            check_all(rv);
        end

        finish_run();
    end
endmodule